// File: doc/BRIEF.md
# SPI flash opcode dispatcher

This block sits behind the serial shifter of a device that emulates an SPI flash part. It looks at the first byte of each transaction, which arrives with a one-cycle valid strobe. It compares that byte against a software-loaded table of command entries. A one-shot state machine then steps from Idle into the handler state that owns the command. The block raises one datapath select line for the handler that follows. It also registers the winning table entry, so downstream logic can read its attributes. The whole block is reset when the chip select rises, so one decode happens per transaction.

Each table entry holds a valid bit, an 8-bit opcode, a read flag, an upload flag and a 2-bit read-pipeline field. The index of an entry fixes its role:
- Slots 0 to 2 hold read-status commands.
- Slot 3 holds the identification read.
- Slot 4 holds the discoverable-parameter read.
- Slots 5 and 6 enter and leave four-byte addressing.
- Slots 7 and 8 set and clear the write latch.
- Slots 9 and up are generic commands.

The busy flag and per-command intercept enables gate some of these roles.

States and their encodings are: ST_IDLE (0), ST_STATUS (1), ST_IDENT (2), ST_PARAMS (3), ST_READ (4), ST_UPLOAD (5), ST_ADDRMODE (6), ST_WRLATCH (7) and ST_DRAIN (8). Every transition leaves ST_IDLE: Idle→Status, Idle→Ident, Idle→Params, Idle→Read, Idle→Upload, Idle→AddrMode, Idle→WrLatch and Idle→Drain. The other states hold until reset.

Top module: `flash_op_dispatch`

## Requirements
- R1: After reset, state_o is 0 (Idle), dp_sel_o is 0, and all latched command outputs (cmd_valid_o, cmd_opcode_o, cmd_read_o, cmd_upload_o, cmd_pipe_o, pipe_two_stage_o) are 0.
- R2: Decoding is enabled only when mode_i is 2'b01 (flash) or 2'b10 (passthrough). With mode_i 2'b00 or 2'b11, a valid byte leaves the block in Idle with all outputs at 0.
- R3: A decode happens only on a clock edge where the state is Idle and rx_valid_i is 1. Its results are visible after that edge. Once the state leaves Idle, state_o, dp_sel_o and the latched command hold through later valid bytes until reset.
- R4: Each entry of cmd_table_i is 13 bits wide, with entry i at bits [13*i+12 : 13*i]. The fields are: bit 12 valid, bits 11:4 opcode, bit 3 read, bit 2 upload, bits 1:0 pipe. An entry is a candidate when its valid bit is 1 and its opcode equals the byte. Among candidates, the lowest index wins.
- R5: A winner in slots 0–2, slot 3 or slot 4 leads to Status (dp_sel_o bit 0), Ident (bit 1) or Params (bit 2) respectively. In flash mode this always happens. In passthrough mode it happens only if icpt_status_i, icpt_jedec_i or icpt_sfdp_i (in the same order) is 1; otherwise the state goes to Drain. Busy has no effect on these slots.
- R6: Slots 5 and 6 are candidates only while busy_i is 0. They lead to AddrMode with dp_sel_o bit 5 (enter) or bit 6 (leave). Slots 7 and 8 are also candidates only while busy_i is 0. They lead to WrLatch with bit 7 (set) or bit 8 (clear).
- R7: A winner in slot 9 or above with its read flag set leads to Read (dp_sel_o bit 3), whatever the value of busy_i. Without the read flag, if its upload flag is set and busy_i is 0, it leads to Upload (bit 4). Otherwise it leads to Drain.
- R8: A valid byte with no candidate leads to Drain, with dp_sel_o 0 and cmd_valid_o 0.
- R9: On the decode edge, the latched command outputs take the winning entry's fields, or all zeros when there is no candidate. A winner that is routed to Drain is still latched.
- R10: pipe_two_stage_o is 1 when the latched pipe field is 2'b01 or 2'b10, and 0 when it is 2'b00 or 2'b11.
- R11: dp_sel_o has at most one bit set. It is 0 in Idle and in Drain. state_o and dp_sel_o are never unknown out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted between transactions |
| mode_i | input | 2 | Interface mode: 01 flash, 10 passthrough, others inactive |
| rx_byte_i | input | 8 | First received byte of the transaction |
| rx_valid_i | input | 1 | rx_byte_i is valid this cycle |
| busy_i | input | 1 | Device busy flag |
| icpt_status_i | input | 1 | Take read-status commands in passthrough mode |
| icpt_jedec_i | input | 1 | Take the identification read in passthrough mode |
| icpt_sfdp_i | input | 1 | Take the parameter read in passthrough mode |
| cmd_table_i | input | 13*NUM_ENTRIES | Packed command table |
| state_o | output | 4 | Current dispatcher state |
| dp_sel_o | output | 9 | One-hot datapath select |
| cmd_valid_o | output | 1 | Latched entry valid bit |
| cmd_opcode_o | output | 8 | Latched entry opcode |
| cmd_read_o | output | 1 | Latched entry read flag |
| cmd_upload_o | output | 1 | Latched entry upload flag |
| cmd_pipe_o | output | 2 | Latched entry read-pipeline field |
| pipe_two_stage_o | output | 1 | Latched pipeline field selects a two-stage pipeline |

## Verification
The bench builds the block with NUM_ENTRIES set to 12. This gives three generic slots besides the nine fixed ones. With that size, a read entry without pipelining, a read entry with a half-cycle pipeline and an upload entry with a full-cycle pipeline can be loaded side by side. It also allows two generic entries that share an opcode, so the lowest-index rule can be observed. Elaboration at the default of 16 entries covers the wider generic range.

// File: rtl/flash_op_dispatch_pkg.sv
package flash_op_dispatch_pkg;

    localparam int OP_W     = 8;
    localparam int ENTRY_W  = 13;
    localparam int DP_W     = 9;

    // fixed slot roles (index decides behaviour)
    localparam int SLOT_STAT_LO = 0;
    localparam int SLOT_STAT_HI = 2;
    localparam int SLOT_IDENT   = 3;
    localparam int SLOT_PARAMS  = 4;
    localparam int SLOT_ADDR_EN = 5;
    localparam int SLOT_ADDR_EX = 6;
    localparam int SLOT_WL_SET  = 7;
    localparam int SLOT_WL_CLR  = 8;
    localparam int SLOT_GENERIC = 9;

    // datapath select bit positions
    localparam int DP_STATUS  = 0;
    localparam int DP_IDENT   = 1;
    localparam int DP_PARAMS  = 2;
    localparam int DP_READ    = 3;
    localparam int DP_UPLOAD  = 4;
    localparam int DP_ADDR_EN = 5;
    localparam int DP_ADDR_EX = 6;
    localparam int DP_WL_SET  = 7;
    localparam int DP_WL_CLR  = 8;

    localparam logic [1:0] MODE_FLASH = 2'b01;
    localparam logic [1:0] MODE_PASS  = 2'b10;

    localparam logic [1:0] PIPE_HALF = 2'b01;
    localparam logic [1:0] PIPE_FULL = 2'b10;

    typedef struct packed {
        logic            valid;
        logic [OP_W-1:0] opcode;
        logic            is_read;
        logic            upload;
        logic [1:0]      pipe;
    } cmd_entry_t;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_STATUS   = 4'd1,
        ST_IDENT    = 4'd2,
        ST_PARAMS   = 4'd3,
        ST_READ     = 4'd4,
        ST_UPLOAD   = 4'd5,
        ST_ADDRMODE = 4'd6,
        ST_WRLATCH  = 4'd7,
        ST_DRAIN    = 4'd8
    } disp_state_e;

endpackage

// File: rtl/fod_slot_match.sv
module fod_slot_match
    import flash_op_dispatch_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES-1:0] ent_valid_i,
    input  logic [OP_W-1:0]        ent_opcode_i [NUM_ENTRIES],
    input  logic [OP_W-1:0]        rx_byte_i,
    input  logic                   busy_i,
    output logic [NUM_ENTRIES-1:0] hit_o
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        logic eq;
        assign eq = ent_valid_i[i] && (ent_opcode_i[i] == rx_byte_i);
        if (i >= SLOT_ADDR_EN && i <= SLOT_WL_CLR) begin : g_gated
            assign hit_o[i] = eq && !busy_i;
        end else begin : g_open
            assign hit_o[i] = eq;
        end
    end

endmodule

// File: rtl/fod_first_hit.sv
module fod_first_hit #(
    parameter int N = 16
) (
    input  logic [N-1:0] hit_i,
    output logic [N-1:0] win_oh_o
);

    always_comb begin
        logic taken;
        taken    = 1'b0;
        win_oh_o = '0;
        for (int i = 0; i < N; i++) begin
            win_oh_o[i] = hit_i[i] && !taken;
            taken       = taken | hit_i[i];
        end
    end

endmodule

// File: rtl/flash_op_dispatch.sv
module flash_op_dispatch
    import flash_op_dispatch_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [1:0]                     mode_i,
    input  logic [7:0]                     rx_byte_i,
    input  logic                           rx_valid_i,
    input  logic                           busy_i,
    input  logic                           icpt_status_i,
    input  logic                           icpt_jedec_i,
    input  logic                           icpt_sfdp_i,
    input  logic [NUM_ENTRIES*13-1:0]      cmd_table_i,
    output logic [3:0]                     state_o,
    output logic [8:0]                     dp_sel_o,
    output logic                           cmd_valid_o,
    output logic [7:0]                     cmd_opcode_o,
    output logic                           cmd_read_o,
    output logic                           cmd_upload_o,
    output logic [1:0]                     cmd_pipe_o,
    output logic                           pipe_two_stage_o
);

    localparam int LAST_SLOT = NUM_ENTRIES - 1;

    cmd_entry_t             tbl [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] ent_valid;
    logic [OP_W-1:0]        ent_opcode [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit;
    logic [NUM_ENTRIES-1:0] win_oh;
    cmd_entry_t             win_ent;

    disp_state_e            state_q, state_d;
    logic [DP_W-1:0]        sel_q, sel_d;
    cmd_entry_t             cmd_q;
    logic                   active, decode_go;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_unpack
        assign tbl[i]        = cmd_entry_t'(cmd_table_i[i*ENTRY_W +: ENTRY_W]);
        assign ent_valid[i]  = tbl[i].valid;
        assign ent_opcode[i] = tbl[i].opcode;
    end

    fod_slot_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .ent_valid_i  (ent_valid),
        .ent_opcode_i (ent_opcode),
        .rx_byte_i    (rx_byte_i),
        .busy_i       (busy_i),
        .hit_o        (hit)
    );

    fod_first_hit #(.N(NUM_ENTRIES)) u_pick (
        .hit_i    (hit),
        .win_oh_o (win_oh)
    );

    always_comb begin
        win_ent = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (win_oh[i]) win_ent = cmd_entry_t'(win_ent | tbl[i]);
        end
    end

    assign active    = (mode_i == MODE_FLASH) || (mode_i == MODE_PASS);
    assign decode_go = (state_q == ST_IDLE) && active && rx_valid_i;

    // routing of the winning slot to a handler
    always_comb begin
        logic in_flash;
        in_flash = (mode_i == MODE_FLASH);
        state_d  = ST_DRAIN;
        sel_d    = '0;
        if (|win_oh[SLOT_STAT_HI:SLOT_STAT_LO]) begin
            if (in_flash || icpt_status_i) begin
                state_d          = ST_STATUS;
                sel_d[DP_STATUS] = 1'b1;
            end
        end else if (win_oh[SLOT_IDENT]) begin
            if (in_flash || icpt_jedec_i) begin
                state_d         = ST_IDENT;
                sel_d[DP_IDENT] = 1'b1;
            end
        end else if (win_oh[SLOT_PARAMS]) begin
            if (in_flash || icpt_sfdp_i) begin
                state_d          = ST_PARAMS;
                sel_d[DP_PARAMS] = 1'b1;
            end
        end else if (win_oh[SLOT_ADDR_EN] || win_oh[SLOT_ADDR_EX]) begin
            state_d = ST_ADDRMODE;
            if (win_oh[SLOT_ADDR_EN]) sel_d[DP_ADDR_EN] = 1'b1;
            else                      sel_d[DP_ADDR_EX] = 1'b1;
        end else if (win_oh[SLOT_WL_SET] || win_oh[SLOT_WL_CLR]) begin
            state_d = ST_WRLATCH;
            if (win_oh[SLOT_WL_SET]) sel_d[DP_WL_SET] = 1'b1;
            else                     sel_d[DP_WL_CLR] = 1'b1;
        end else if (|win_oh[LAST_SLOT:SLOT_GENERIC]) begin
            if (win_ent.is_read) begin
                state_d        = ST_READ;
                sel_d[DP_READ] = 1'b1;
            end else if (win_ent.upload && !busy_i) begin
                state_d          = ST_UPLOAD;
                sel_d[DP_UPLOAD] = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else if (decode_go) begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
            cmd_q <= '0;
        end else if (decode_go) begin
            sel_q <= sel_d;
            cmd_q <= win_ent;
        end
    end

    assign state_o          = state_q;
    assign dp_sel_o         = sel_q;
    assign cmd_valid_o      = cmd_q.valid;
    assign cmd_opcode_o     = cmd_q.opcode;
    assign cmd_read_o       = cmd_q.is_read;
    assign cmd_upload_o     = cmd_q.upload;
    assign cmd_pipe_o       = cmd_q.pipe;
    assign pipe_two_stage_o = (cmd_q.pipe == PIPE_HALF) || (cmd_q.pipe == PIPE_FULL);

endmodule

// File: rtl/fod_checker.sv
module fod_checker
    import flash_op_dispatch_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode_i,
    input logic       rx_valid_i,
    input logic       busy_i,
    input logic [3:0] state_o,
    input logic [8:0] dp_sel_o,
    input logic       cmd_valid_o
);

    AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(dp_sel_o)); // R11

    AST_NO_UNKNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown({state_o, dp_sel_o})); // R11

    AST_QUIET_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_IDLE || state_o == ST_DRAIN) |-> dp_sel_o == '0); // R11

    AST_HOLD_AFTER_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o != ST_IDLE) |=> ($stable(state_o) && $stable(dp_sel_o) && $stable(cmd_valid_o))); // R3

    AST_NEED_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_IDLE && !rx_valid_i) |=> state_o == ST_IDLE); // R3

    AST_INACTIVE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_IDLE && mode_i != MODE_FLASH && mode_i != MODE_PASS) |=> state_o == ST_IDLE); // R2

    AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_IDLE && busy_i) |=> (state_o != ST_ADDRMODE && state_o != ST_WRLATCH)); // R6

endmodule

bind flash_op_dispatch fod_checker u_fod_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .rx_valid_i  (rx_valid_i),
    .busy_i      (busy_i),
    .state_o     (state_o),
    .dp_sel_o    (dp_sel_o),
    .cmd_valid_o (cmd_valid_o)
);

// File: tb/test_flash_op_dispatch.sv
`timescale 1ns/1ps
module test_flash_op_dispatch;

    localparam int N = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode = 2'b00;
    logic [7:0]     rx_byte = 8'h00;
    logic           rx_valid = 1'b0;
    logic           busy = 1'b0;
    logic [2:0]     icpt = 3'b000;
    logic [N*13-1:0] table_v = '0;

    logic [3:0] state_o;
    logic [8:0] dp_sel_o;
    logic       cmd_valid_o, cmd_read_o, cmd_upload_o, two_stage_o;
    logic [7:0] cmd_opcode_o;
    logic [1:0] cmd_pipe_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    flash_op_dispatch #(.NUM_ENTRIES(N)) i_flash_op_dispatch (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .mode_i           (mode),
        .rx_byte_i        (rx_byte),
        .rx_valid_i       (rx_valid),
        .busy_i           (busy),
        .icpt_status_i    (icpt[0]),
        .icpt_jedec_i     (icpt[1]),
        .icpt_sfdp_i      (icpt[2]),
        .cmd_table_i      (table_v),
        .state_o          (state_o),
        .dp_sel_o         (dp_sel_o),
        .cmd_valid_o      (cmd_valid_o),
        .cmd_opcode_o     (cmd_opcode_o),
        .cmd_read_o       (cmd_read_o),
        .cmd_upload_o     (cmd_upload_o),
        .cmd_pipe_o       (cmd_pipe_o),
        .pipe_two_stage_o (two_stage_o)
    );

    // {req, mode, busy, icpt, byte, exp_state, exp_sel, exp_valid, exp_opcode, exp_two_stage}
    localparam logic [40:0] VEC [25] = '{
        {4'd5, 2'd1, 1'b0, 3'b000, 8'h05, 4'd1, 9'h001, 1'b1, 8'h05, 1'b0}, // R5 status slot0
        {4'd5, 2'd1, 1'b0, 3'b000, 8'h35, 4'd1, 9'h001, 1'b1, 8'h35, 1'b0}, // R5 status slot1
        {4'd4, 2'd1, 1'b0, 3'b000, 8'h15, 4'd8, 9'h000, 1'b0, 8'h00, 1'b0}, // R4 invalid slot2
        {4'd5, 2'd1, 1'b0, 3'b000, 8'h9F, 4'd2, 9'h002, 1'b1, 8'h9F, 1'b0}, // R5 ident
        {4'd5, 2'd1, 1'b0, 3'b000, 8'h5A, 4'd3, 9'h004, 1'b1, 8'h5A, 1'b0}, // R5 params
        {4'd5, 2'd2, 1'b0, 3'b000, 8'h05, 4'd8, 9'h000, 1'b1, 8'h05, 1'b0}, // R5 R9 passthrough no intercept
        {4'd5, 2'd2, 1'b0, 3'b001, 8'h05, 4'd1, 9'h001, 1'b1, 8'h05, 1'b0}, // R5
        {4'd5, 2'd2, 1'b0, 3'b010, 8'h9F, 4'd2, 9'h002, 1'b1, 8'h9F, 1'b0}, // R5
        {4'd5, 2'd2, 1'b0, 3'b011, 8'h5A, 4'd8, 9'h000, 1'b1, 8'h5A, 1'b0}, // R5
        {4'd5, 2'd2, 1'b0, 3'b100, 8'h5A, 4'd3, 9'h004, 1'b1, 8'h5A, 1'b0}, // R5
        {4'd6, 2'd1, 1'b0, 3'b000, 8'hB7, 4'd6, 9'h020, 1'b1, 8'hB7, 1'b0}, // R6 enter
        {4'd6, 2'd1, 1'b0, 3'b000, 8'hE9, 4'd6, 9'h040, 1'b1, 8'hE9, 1'b0}, // R6 leave
        {4'd6, 2'd1, 1'b1, 3'b000, 8'hB7, 4'd8, 9'h000, 1'b0, 8'h00, 1'b0}, // R6 busy
        {4'd6, 2'd1, 1'b0, 3'b000, 8'h06, 4'd7, 9'h080, 1'b1, 8'h06, 1'b0}, // R6 set latch
        {4'd6, 2'd1, 1'b0, 3'b000, 8'h04, 4'd7, 9'h100, 1'b1, 8'h04, 1'b0}, // R6 clear latch
        {4'd6, 2'd1, 1'b1, 3'b000, 8'h04, 4'd8, 9'h000, 1'b0, 8'h00, 1'b0}, // R6 busy
        {4'd7, 2'd1, 1'b0, 3'b000, 8'h03, 4'd4, 9'h008, 1'b1, 8'h03, 1'b0}, // R7 read
        {4'd7, 2'd1, 1'b1, 3'b000, 8'h0B, 4'd4, 9'h008, 1'b1, 8'h0B, 1'b1}, // R7 R10 read while busy
        {4'd7, 2'd1, 1'b0, 3'b000, 8'h02, 4'd5, 9'h010, 1'b1, 8'h02, 1'b1}, // R7 upload
        {4'd7, 2'd1, 1'b1, 3'b000, 8'h02, 4'd8, 9'h000, 1'b1, 8'h02, 1'b1}, // R7 R9 upload busy
        {4'd2, 2'd2, 1'b0, 3'b000, 8'h03, 4'd4, 9'h008, 1'b1, 8'h03, 1'b0}, // R2 passthrough active
        {4'd8, 2'd1, 1'b0, 3'b000, 8'h77, 4'd8, 9'h000, 1'b0, 8'h00, 1'b0}, // R8 no match
        {4'd2, 2'd0, 1'b0, 3'b111, 8'h05, 4'd0, 9'h000, 1'b0, 8'h00, 1'b0}, // R2 inactive 00
        {4'd2, 2'd3, 1'b0, 3'b111, 8'h05, 4'd0, 9'h000, 1'b0, 8'h00, 1'b0}, // R2 inactive 11
        {4'd5, 2'd1, 1'b1, 3'b000, 8'h05, 4'd1, 9'h001, 1'b1, 8'h05, 1'b0}  // R5 busy ignored
    };

    function automatic logic [12:0] ent(input logic v, input logic [7:0] op,
                                        input logic rd, input logic up, input logic [1:0] p);
        return {v, op, rd, up, p};
    endfunction

    task automatic set_slot(input int idx, input logic [12:0] e);
        table_v[idx*13 +: 13] = e;
    endtask

    task automatic load_table();
        set_slot(0,  ent(1'b1, 8'h05, 1'b0, 1'b0, 2'b00));
        set_slot(1,  ent(1'b1, 8'h35, 1'b0, 1'b0, 2'b00));
        set_slot(2,  ent(1'b0, 8'h15, 1'b0, 1'b0, 2'b00));
        set_slot(3,  ent(1'b1, 8'h9F, 1'b0, 1'b0, 2'b00));
        set_slot(4,  ent(1'b1, 8'h5A, 1'b0, 1'b0, 2'b00));
        set_slot(5,  ent(1'b1, 8'hB7, 1'b0, 1'b0, 2'b00));
        set_slot(6,  ent(1'b1, 8'hE9, 1'b0, 1'b0, 2'b00));
        set_slot(7,  ent(1'b1, 8'h06, 1'b0, 1'b0, 2'b00));
        set_slot(8,  ent(1'b1, 8'h04, 1'b0, 1'b0, 2'b00));
        set_slot(9,  ent(1'b1, 8'h03, 1'b1, 1'b0, 2'b00));
        set_slot(10, ent(1'b1, 8'h0B, 1'b1, 1'b0, 2'b01));
        set_slot(11, ent(1'b1, 8'h02, 1'b0, 1'b1, 2'b10));
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rx_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n    = 1'b1;
    endtask

    task automatic send(input logic [1:0] m, input logic b, input logic [2:0] ic, input logic [7:0] d);
        mode     = m;
        busy     = b;
        icpt     = ic;
        rx_byte  = d;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    function automatic logic [31:0] obs();
        return {9'd0, state_o, dp_sel_o, cmd_valid_o, cmd_opcode_o, two_stage_o};
    endfunction

    initial begin
        load_table();
        do_reset();

        // R1 reset state
        check("R1", {8'd0, state_o, dp_sel_o, cmd_valid_o, cmd_opcode_o, cmd_read_o, cmd_upload_o},
              32'd0);
        check("R1", {29'd0, cmd_pipe_o, two_stage_o}, 32'd0);

        // vector table
        for (int k = 0; k < 25; k++) begin
            logic [40:0] v;
            string tag;
            v = VEC[k];
            do_reset();
            send(v[36:35], v[34], v[33:31], v[30:23]);
            tag = $sformatf("R%0d vec%0d", v[40:37], k);
            check(tag, obs(), {9'd0, v[22:0]});
        end

        // R9 attribute fields of the upload entry
        do_reset();
        send(2'd1, 1'b0, 3'b000, 8'h02);
        check("R9", {28'd0, cmd_read_o, cmd_upload_o, cmd_pipe_o}, {28'd0, 1'b0, 1'b1, 2'b10});

        // R3 no strobe keeps Idle
        do_reset();
        mode = 2'd1; rx_byte = 8'h05;
        repeat (3) @(negedge clk);
        check("R3 no strobe", {28'd0, state_o}, 32'd0);

        // R3 hold after dispatch despite later bytes
        send(2'd1, 1'b0, 3'b000, 8'h05);
        send(2'd1, 1'b0, 3'b000, 8'h06);
        send(2'd1, 1'b0, 3'b000, 8'hB7);
        check("R3 hold", obs(), {9'd0, 4'd1, 9'h001, 1'b1, 8'h05, 1'b0});

        // R8 drain ignores the rest
        do_reset();
        send(2'd1, 1'b0, 3'b000, 8'h77);
        send(2'd1, 1'b0, 3'b000, 8'h05);
        check("R8 drain hold", obs(), {9'd0, 4'd8, 9'h000, 1'b0, 8'h00, 1'b0});

        // R4 lowest index wins among duplicate opcodes
        set_slot(10, ent(1'b1, 8'h03, 1'b0, 1'b1, 2'b01));
        do_reset();
        send(2'd1, 1'b0, 3'b000, 8'h03);
        check("R4 priority", {23'd0, state_o, cmd_read_o, cmd_upload_o, cmd_pipe_o, two_stage_o},
              {23'd0, 4'd4, 1'b1, 1'b0, 2'b00, 1'b0});

        // R10 pipe code 11 is not two-stage
        set_slot(9, ent(1'b1, 8'h03, 1'b1, 1'b0, 2'b11));
        do_reset();
        send(2'd1, 1'b0, 3'b000, 8'h03);
        check("R10 pipe 11", {29'd0, cmd_pipe_o, two_stage_o}, {29'd0, 2'b11, 1'b0});
        load_table();

        // R1 reset mid-transaction returns to Idle
        do_reset();
        send(2'd1, 1'b0, 3'b000, 8'h9F);
        do_reset();
        check("R1 re-reset", obs(), 32'd0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R3 actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule